// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 2^18 words of 16 bits. It accepts one single-word read or write at a time. For each one it produces a strobe sequence on the RAM pins, with every phase length counted in clock cycles. Those counts are derived from nanosecond timing parameters and the clock period, rounded up. The RAM control pins are all active low: chip select, write strobe, output enable, and one enable for each byte lane. The 16-bit data bus is handled as three separate signals: an output word, an output-enable and an input word. The pad buffer is outside the block.

A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A two-bit lane mask picks the bytes that take part. Bit 0 selects data bits 7..0 (`mem_lb_n`) and bit 1 selects bits 15..8 (`mem_ub_n`). A read returns its word in `rd_data`, with the one-cycle strobe `rd_valid`. The word is captured on the edge where the access time has run out. A write is framed by a setup cycle, a write-strobe pulse and a hold cycle. The block drives the bus only after the RAM has had time to release it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are high, mem_dq_oe and rd_valid are low, and req_ready is high.
- R2: A read taken at edge E holds mem_cs_n and mem_oe_n low and mem_we_n high for ceil(max(access, cycle-1 period) / clock) cycles, which is 6 at defaults, starting the cycle after E. mem_addr equals the request address, and mem_lb_n / mem_ub_n are low exactly for mask bits 0 / 1 that are set.
- R3: The read word is sampled on the last edge of the read window. rd_valid is high for exactly the following cycle. rd_data carries mem_dq_in on enabled lanes and zero on disabled lanes.
- R4: A write taken at edge E gives one setup cycle (mem_cs_n low, mem_we_n high), then mem_we_n low for 4 cycles (the larger of the pulse, data setup, byte setup, and cycle time minus setup and hold), then one hold cycle with mem_we_n high and mem_cs_n still low. mem_oe_n stays high throughout.
- R5: During a write, mem_dq_oe is high from the first write-strobe cycle through the hold cycle, and mem_dq_out equals the request data. Otherwise mem_dq_oe is low.
- R6: mem_addr and the byte-lane enables never change while mem_we_n is low. The address is loaded only when a request is taken.
- R7: req_ready is high only while no access is in progress. Chip select returns high for at least one cycle between two accesses. With no request pending the RAM pins stay inactive.
- R8: After a read, a write request is refused (req_ready low) for the first ceil(output-release / clock) - setup - 1 idle cycles, which is 1 at defaults. A read request is accepted at once. The bus is not driven until output enable has been high for at least two cycles.
- R9: A request with mask 00 is taken, produces no strobe and no rd_valid, and leaves req_ready high.
- R10: mem_we_n and mem_oe_n are never low together, and mem_dq_oe is never high while mem_oe_n is low or within the output-release time after the RAM last drove the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| req_ready | output | 1 | Request taken when high together with req_valid |
| rd_data | output | 16 | Captured read word, disabled lanes zero |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM low byte enable, active low |
| mem_ub_n | output | 1 | RAM high byte enable, active low |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
The bench models the RAM at pin level. It stores a word only when the write strobe rises during chip select. It returns junk on lanes that are not enabled. A design that took the lane polarity or the write-strobe edge wrong therefore reads back corrupted words, and one that skipped masking leaks 0xEE bytes into rd_data. The bench times a write that directly follows a read, and it tracks how long the RAM may still drive the bus. A missing turnaround cycle shows up as a bus-contention failure. Empty-mask requests and address changes under a low write strobe are compared cycle by cycle against a per-cycle expected frame.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_WSETUP = 3'd2,
    PH_WPULSE = 3'd3,
    PH_WHOLD  = 3'd4
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_cycles(input int ns, input int per);
    return (ns <= 0) ? 0 : (ns + per - 1) / per;
  endfunction

  function automatic int setup_cycles(input int t_as, input int per);
    return imax(1, ns_cycles(t_as, per));
  endfunction

  function automatic int hold_cycles(input int t_dh, input int per);
    return imax(1, ns_cycles(t_dh, per));
  endfunction

  function automatic int pulse_cycles(input int t_wp, input int t_dw, input int t_bw,
                                      input int t_wc, input int t_as, input int t_dh,
                                      input int per);
    int edge_min;
    int cyc_min;
    edge_min = imax(ns_cycles(t_wp, per), imax(ns_cycles(t_dw, per), ns_cycles(t_bw, per)));
    cyc_min  = ns_cycles(t_wc, per) - setup_cycles(t_as, per) - hold_cycles(t_dh, per);
    return imax(1, imax(edge_min, cyc_min));
  endfunction

  // chip select low window of a read; one idle cycle follows it
  function automatic int read_cycles(input int t_acc, input int t_rc, input int per);
    return imax(1, imax(ns_cycles(t_acc, per), ns_cycles(t_rc, per) - 1));
  endfunction

  // idle cycles a write waits after a read so the RAM has released the bus
  function automatic int turn_cycles(input int t_ohz, input int t_as, input int per);
    return imax(0, ns_cycles(t_ohz, per) - setup_cycles(t_as, per) - 1);
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int SU_CYC = 1,
  parameter int PL_CYC = 4,
  parameter int HD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic idle,
  output logic act_nx,
  output logic rd_capture,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic drv
);

  localparam int MAXC  = imax(imax(RD_CYC, SU_CYC), imax(PL_CYC, HD_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);

  phase_e           ph_q, ph_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             ph_done;

  function automatic logic [CNT_W-1:0] len_of(input int n);
    return CNT_W'(n - 1);
  endfunction

  assign ph_done = (cnt_q == '0);
  assign idle    = (ph_q == PH_IDLE);
  assign act_nx  = (ph_nx != PH_IDLE);

  always_comb begin
    ph_nx      = ph_q;
    cnt_nx     = ph_done ? cnt_q : cnt_q - 1'b1;
    rd_capture = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_nx = '0;
        if (start) begin
          ph_nx  = start_wr ? PH_WSETUP : PH_READ;
          cnt_nx = start_wr ? len_of(SU_CYC) : len_of(RD_CYC);
        end
      end
      PH_READ: begin
        if (ph_done) begin
          ph_nx      = PH_IDLE;
          rd_capture = 1'b1;
        end
      end
      PH_WSETUP: begin
        if (ph_done) begin
          ph_nx  = PH_WPULSE;
          cnt_nx = len_of(PL_CYC);
        end
      end
      PH_WPULSE: begin
        if (ph_done) begin
          ph_nx  = PH_WHOLD;
          cnt_nx = len_of(HD_CYC);
        end
      end
      PH_WHOLD: begin
        if (ph_done) ph_nx = PH_IDLE;
      end
      default: begin
        ph_nx  = PH_IDLE;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drv   <= 1'b0;
    end else begin
      ph_q  <= ph_nx;
      cnt_q <= cnt_nx;
      cs_n  <= (ph_nx == PH_IDLE);
      we_n  <= (ph_nx != PH_WPULSE);
      oe_n  <= (ph_nx != PH_READ);
      drv   <= (ph_nx == PH_WPULSE) || (ph_nx == PH_WHOLD);
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({~we_n, ~oe_n})) else $error("we/oe both low"); // R10
  AST_WE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !cs_n) else $error("write strobe outside select"); // R4
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> !cs_n && drv) else $error("no hold cycle"); // R4
  AST_CAPTURE_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_capture |-> !oe_n && !cs_n) else $error("capture outside read"); // R3

endmodule

// File: rtl/sram_ctl_turn.sv
`timescale 1ns/1ps
module sram_ctl_turn #(
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_done,
  output logic block
);

  localparam int TW = (TURN_CYC > 0) ? $clog2(TURN_CYC + 1) : 1;

  logic [TW-1:0] left_q;

  assign block = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (rd_done) begin
      left_q <= TW'(TURN_CYC);
    end else if (block) begin
      left_q <= left_q - 1'b1;
    end
  end

  AST_TURN_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (block && !rd_done) |=> (left_q < $past(left_q))) else $error("turn counter stuck"); // R8

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
  parameter int AW    = 18,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    ld_addr,
  input  logic [DW-1:0]    ld_data,
  input  logic [LANES-1:0] ld_mask,
  input  logic             act_nx,
  input  logic             capture,
  input  logic [DW-1:0]    dq_in,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] lane_n,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);

  localparam int LW = DW / LANES;

  logic [LANES-1:0] mask_q, mask_use, lane_nx;
  logic [DW-1:0]    rd_nx;

  assign mask_use = load ? ld_mask : mask_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_nx[g]          = ~(act_nx & mask_use[g]);
    assign rd_nx[g*LW +: LW]   = mask_q[g] ? dq_in[g*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wr_data  <= '0;
      mask_q   <= '0;
      lane_n   <= '1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (load) begin
        mem_addr <= ld_addr;
        wr_data  <= ld_data;
        mask_q   <= ld_mask;
      end
      lane_n   <= lane_nx;
      rd_valid <= capture;
      if (capture) rd_data <= rd_nx;
    end
  end

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid) else $error("rd_valid longer than one cycle"); // R3
  AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !mask_q[0]) |-> (rd_data[LW-1:0] == '0)) else $error("disabled low lane nonzero"); // R3

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_ACC_NS      = 55,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 30,
  parameter int T_DW_NS       = 25,
  parameter int T_BW_NS       = 25,
  parameter int T_AS_NS       = 0,
  parameter int T_DH_NS       = 0,
  parameter int T_OHZ_NS      = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int LANES  = 2;
  localparam int RD_CYC = read_cycles(T_ACC_NS, T_RC_NS, CLK_PERIOD_NS);
  localparam int SU_CYC = setup_cycles(T_AS_NS, CLK_PERIOD_NS);
  localparam int HD_CYC = hold_cycles(T_DH_NS, CLK_PERIOD_NS);
  localparam int PL_CYC = pulse_cycles(T_WP_NS, T_DW_NS, T_BW_NS, T_WC_NS,
                                       T_AS_NS, T_DH_NS, CLK_PERIOD_NS);
  localparam int TURN   = turn_cycles(T_OHZ_NS, T_AS_NS, CLK_PERIOD_NS);

  // named internal events
  logic             seq_idle;
  logic             seq_act_nx;
  logic             ev_accept;
  logic             ev_start;
  logic             ev_rd_capture;
  logic             turn_block;
  logic [LANES-1:0] lane_n;

  assign req_ready = seq_idle && !(req_write && turn_block);
  assign ev_accept = req_valid && req_ready;
  assign ev_start  = ev_accept && (req_mask != '0);

  sram_ctl_seq #(
    .RD_CYC (RD_CYC),
    .SU_CYC (SU_CYC),
    .PL_CYC (PL_CYC),
    .HD_CYC (HD_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_start),
    .start_wr   (req_write),
    .idle       (seq_idle),
    .act_nx     (seq_act_nx),
    .rd_capture (ev_rd_capture),
    .cs_n       (mem_cs_n),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .drv        (mem_dq_oe)
  );

  sram_ctl_turn #(
    .TURN_CYC (TURN)
  ) u_turn (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_done (ev_rd_capture),
    .block   (turn_block)
  );

  sram_ctl_dpath #(
    .AW    (AW),
    .DW    (DW),
    .LANES (LANES)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_start),
    .ld_addr  (req_addr),
    .ld_data  (req_wdata),
    .ld_mask  (req_mask),
    .act_nx   (seq_act_nx),
    .capture  (ev_rd_capture),
    .dq_in    (mem_dq_in),
    .mem_addr (mem_addr),
    .wr_data  (mem_dq_out),
    .lane_n   (lane_n),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> $stable(mem_addr)) else $error("address moved under write strobe"); // R6
  AST_LANES_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> $stable({mem_lb_n, mem_ub_n})) else $error("lanes moved under write strobe"); // R6
  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n) else $error("bus driven with output enable low"); // R10
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_dq_oe) else $error("write strobe without data"); // R5
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_cs_n) else $error("ready during access"); // R7
  AST_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n) (ev_accept && req_mask == 2'b00) |=> mem_cs_n) else $error("empty mask started access"); // R9
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> $past(mem_oe_n, 1) && $past(mem_oe_n, 2)) else $error("drive too soon after read"); // R8
  AST_IDLE_LANES: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n |-> (mem_lb_n && mem_ub_n)) else $error("lane enable outside select"); // R2

endmodule

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int PER = 10;
  // phase lengths restated from the timing figures
  localparam int RD_N   = 6;  // 55 ns access -> 6 cycles
  localparam int PL_N   = 4;  // 55 ns cycle - setup - hold, at least 30 ns pulse
  localparam int HZ_N   = 3;  // 30 ns release -> 3 cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = 16'hEEEE;

  always #(PER/2) clk = ~clk;

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct packed {
    logic [6:0]  pins;   // cs we oe lb ub dq_oe rv
    logic [17:0] addr;
    logic [15:0] dq;
    logic [15:0] rd;
  } frame_t;

  frame_t      fq[$];
  string       tq[$];
  logic [15:0] ref_mem [int];
  logic [15:0] pin_mem [int];
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;
  bit          running = 1'b0;
  int          hz_left = 0;
  logic        p_act = 1'b0;
  logic [17:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  logic        p_lb = 1'b1, p_ub = 1'b1;

  function automatic logic [15:0] seed_of(input logic [17:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[17:16], 14'h0};
  endfunction

  function automatic logic [15:0] ref_get(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : seed_of(a);
  endfunction

  function automatic logic [15:0] pin_get(input logic [17:0] a);
    return pin_mem.exists(int'(a)) ? pin_mem[int'(a)] : seed_of(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // per-cycle comparison and pin-level RAM model
  always @(negedge clk) begin
    frame_t f;
    string  t;
    logic [6:0] got;
    if (running) begin
      if (fq.size() > 0) begin
        f = fq.pop_front();
        t = tq.pop_front();
      end else begin
        f = '{pins: 7'b1111100, addr: '0, dq: '0, rd: '0};
        t = "R7";
      end
      got = {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rd_valid};
      chk(got == f.pins, t, "pins cs,we,oe,lb,ub,dq_oe,rv", 64'(got), 64'(f.pins));
      if (!f.pins[6]) chk(mem_addr == f.addr, "R6", "mem_addr", 64'(mem_addr), 64'(f.addr));
      if (f.pins[1])  chk(mem_dq_out == f.dq, "R5", "mem_dq_out", 64'(mem_dq_out), 64'(f.dq));
      if (f.pins[0])  chk(rd_data == f.rd, "R3", "rd_data", 64'(rd_data), 64'(f.rd));
    end
    // bus release tracking
    if (hz_left > 0) hz_left--;
    if (mem_dq_oe) chk(hz_left == 0 && mem_oe_n, "R10", "drive while RAM may drive", 64'(hz_left), 64'(0));
    if (!mem_cs_n && !mem_oe_n && mem_we_n) hz_left = HZ_N;
    // write commit at end of strobe overlap
    if (p_act && !(!mem_cs_n && !mem_we_n)) begin
      logic [15:0] w;
      w = pin_get(p_addr);
      if (!p_lb) w[7:0]  = p_dq[7:0];
      if (!p_ub) w[15:8] = p_dq[15:8];
      pin_mem[int'(p_addr)] = w;
    end
    p_act  = !mem_cs_n && !mem_we_n;
    p_addr = mem_addr;
    p_dq   = mem_dq_out;
    p_lb   = mem_lb_n;
    p_ub   = mem_ub_n;
    // RAM read drive, junk on disabled lanes
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      logic [15:0] r;
      r = pin_get(mem_addr);
      mem_dq_in <= {mem_ub_n ? 8'hEE : r[15:8], mem_lb_n ? 8'hEE : r[7:0]};
    end else begin
      mem_dq_in <= 16'hEEEE;
    end
  end

  task automatic push_frames(input bit wr, input logic [17:0] a, input logic [15:0] d,
                             input logic [1:0] m);
    logic lb, ub;
    logic [15:0] v;
    lb = !m[0];
    ub = !m[1];
    if (m == 2'b00) return;
    if (!wr) begin
      v = ref_get(a);
      for (int i = 0; i < RD_N; i++) begin
        fq.push_back('{pins: {1'b0, 1'b1, 1'b0, lb, ub, 1'b0, 1'b0}, addr: a, dq: '0, rd: '0});
        tq.push_back("R2");
      end
      fq.push_back('{pins: 7'b1111101, addr: '0, dq: '0,
                     rd: {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00}});
      tq.push_back("R3");
    end else begin
      fq.push_back('{pins: {1'b0, 1'b1, 1'b1, lb, ub, 1'b0, 1'b0}, addr: a, dq: '0, rd: '0});
      tq.push_back("R4");
      for (int i = 0; i < PL_N; i++) begin
        fq.push_back('{pins: {1'b0, 1'b0, 1'b1, lb, ub, 1'b1, 1'b0}, addr: a, dq: d, rd: '0});
        tq.push_back("R4");
      end
      fq.push_back('{pins: {1'b0, 1'b1, 1'b1, lb, ub, 1'b1, 1'b0}, addr: a, dq: d, rd: '0});
      tq.push_back("R5");
      v = ref_get(a);
      if (m[0]) v[7:0]  = d[7:0];
      if (m[1]) v[15:8] = d[15:8];
      ref_mem[int'(a)] = v;
    end
  endtask

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    push_frames(wr, a, d, m);
  endtask

  task automatic wait_rdv();
    @(negedge clk);
    while (!rd_valid) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] lf;
    int seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1", "strobes in reset",
        64'({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 64'h1F);
    chk(!mem_dq_oe && !rd_valid, "R1", "dq_oe/rd_valid in reset", 64'({mem_dq_oe, rd_valid}), 64'h0);
    chk(req_ready, "R1", "ready in reset", 64'(req_ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_n, "R1", "ready after reset", 64'({req_ready, mem_cs_n}), 64'h3);
    running = 1'b1;

    // full, lower-only and upper-only writes, address extremes
    issue(1'b1, 18'h00000, 16'h1234, 2'b11);
    issue(1'b1, 18'h3FFFF, 16'hBEEF, 2'b11);
    issue(1'b1, 18'h00010, 16'hAA55, 2'b01);
    issue(1'b1, 18'h00011, 16'h6699, 2'b10);
    issue(1'b0, 18'h00000, 16'h0000, 2'b11);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b01);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b10);
    issue(1'b0, 18'h00010, 16'h0000, 2'b11);
    issue(1'b0, 18'h00011, 16'h0000, 2'b11);

    // R9: empty-mask write then read leave nothing behind
    issue(1'b1, 18'h00020, 16'hFFFF, 2'b00);
    @(negedge clk); #1;
    chk(req_ready, "R9", "ready after empty request", 64'(req_ready), 64'h1);
    issue(1'b0, 18'h00020, 16'h0000, 2'b00);
    seen = 0;
    for (int i = 0; i < RD_N + 2; i++) begin
      @(negedge clk);
      if (rd_valid) seen++;
    end
    chk(seen == 0, "R9", "rd_valid count after empty read", 64'(seen), 64'h0);
    issue(1'b0, 18'h00020, 16'h0000, 2'b11);

    // R8: write directly after a read waits one idle cycle
    issue(1'b0, 18'h00030, 16'h0000, 2'b11);
    wait_rdv();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00030; req_wdata = 16'h0F0F; req_mask = 2'b11;
    #1;
    chk(!req_ready, "R8", "write refused in turnaround", 64'(req_ready), 64'h0);
    @(negedge clk); #1;
    chk(req_ready, "R8", "write accepted after turnaround", 64'(req_ready), 64'h1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    push_frames(1'b1, 18'h00030, 16'h0F0F, 2'b11);

    // R8: read after read accepted at once
    issue(1'b0, 18'h00030, 16'h0000, 2'b11);
    wait_rdv();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00000; req_mask = 2'b11;
    #1;
    chk(req_ready, "R8", "read accepted right after read", 64'(req_ready), 64'h1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    push_frames(1'b0, 18'h00000, 16'h0000, 2'b11);

    // mixed traffic from an LFSR
    lf = 32'hACE1_2468;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf[7], {lf[20] ? 14'h3FF0 : 14'h0000, lf[3:0]}, lf[31:16], lf[6:5]);
    end

    repeat (12) @(negedge clk);
    chk(fq.size() == 0, "R7", "expected frames left", 64'(fq.size()), 64'h0);
    summary();
  end

endmodule